// File: doc/BRIEF.md
# Register-Programmed Single-Operation Bus Sequencer

This block runs one software-issued transfer at a time against a downstream bus engine. Software first loads a byte count, a target address and, for outbound transfers, the payload into sixteen 32-bit data words. It then writes an opcode and sets a start bit. While the sequencer is active, it raises a request to the engine. It streams payload bytes out and stores returned bytes back into the same data words. It finishes when the engine reports done.

A transfer moves at most 64 bytes, which is the capacity of the data words. While a transfer is running, every write to configuration or data is refused and a sticky sequence error is recorded. A count or opcode that cannot be served is rejected before any bus activity starts. The done flag tells software when read data is valid and when a new transfer may start. It can also drive a level interrupt.

Top module: `pio_seq`

## Requirements
- R1: After reset, all register fields and status bits read zero, and `bus_req_o`, `tx_valid_o` and `irq_o` are low.
- R2: The register word addresses are CTRL=0, COUNT=1, TARGET=2, OPCODE=3 and STATUS=4. The data words sit at 16+i. A CTRL write with bit0 set while idle starts a transfer. From the next cycle, STATUS bit0 (busy) and CTRL bit0 read 1. In the same cycles, `bus_req_o` is high, `bus_len_o` equals COUNT, `bus_addr_o` equals TARGET and `bus_op_o` gives the kind (1 read, 2 write, 3 write-then-read). The cycle after `bus_done_i` is sampled, busy and CTRL bit0 read 0 and STATUS bit1 (done) reads 1.
- R3: Opcode 0xA2 (write) presents payload bytes 0..COUNT-1 on `tx_data_o`, in order. Byte k is bits 8*(k%4)+7:8*(k%4) of data word k/4. A byte advances only on a cycle where `tx_valid_o` and `tx_ready_i` are both high.
- R4: Opcode 0xA1 (read) stores the k-th accepted `rx_data_i` byte at byte k of the data words, using the same layout. Bytes at or beyond COUNT keep their previous value.
- R5: Opcode 0xA3 (write-then-read) first sends COUNT bytes as in R3 and then accepts COUNT bytes as in R4. Receive bytes offered before the last transmit byte has been taken are ignored.
- R6: While busy, a write to CTRL, COUNT, TARGET, OPCODE or any data word has no effect and sets STATUS bit2 (sequence error). A STATUS write is still honoured.
- R7: A start request with COUNT of 0, COUNT above 64, or an opcode other than 0xA1, 0xA2 or 0xA3 sets STATUS bit3 (configuration error). It leaves busy low and raises no request.
- R8: STATUS bits 1, 2 and 3 clear when 1 is written to them. A set event in the same cycle takes priority over the clear.
- R9: `irq_o` equals done AND CTRL bit1 (interrupt enable). CTRL bit1 is written by any CTRL write while idle.
- R10: `tx_valid_o` is low once COUNT bytes have been sent. `rx_valid_i` beyond COUNT bytes is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Done interrupt, level |
| bus_req_o | output | 1 | Request to the bus engine, held while busy |
| bus_op_o | output | 2 | Transfer kind: 1 read, 2 write, 3 write-then-read |
| bus_addr_o | output | 24 | Target address |
| bus_len_o | output | 7 | Byte count |
| bus_done_i | input | 1 | Engine reports the end of the transfer |
| tx_valid_o | output | 1 | Outbound byte valid |
| tx_data_o | output | 8 | Outbound byte |
| tx_ready_i | input | 1 | Engine takes the outbound byte |
| rx_valid_i | input | 1 | Inbound byte valid |
| rx_data_i | input | 8 | Inbound byte |

## Verification
The engine's done report and a register write refused for being busy can land in the same clock. The bench provokes this by driving `bus_done_i` together with a data-word write, and separately together with a STATUS clear of an already set done bit. It then judges the outcome. The refused word must be unchanged, and the sequence error and done must both be set. A done clear that coincides with a new completion must leave done at 1.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  localparam int REG_CTRL   = 0;
  localparam int REG_COUNT  = 1;
  localparam int REG_TARGET = 2;
  localparam int REG_OPCODE = 3;
  localparam int REG_STATUS = 4;

  localparam logic [7:0] OPC_READ  = 8'hA1;
  localparam logic [7:0] OPC_WRITE = 8'hA2;
  localparam logic [7:0] OPC_WRRD  = 8'hA3;

  typedef enum logic [1:0] {
    BOP_NONE  = 2'd0,
    BOP_READ  = 2'd1,
    BOP_WRITE = 2'd2,
    BOP_WRRD  = 2'd3
  } bus_op_e;

  function automatic bus_op_e op_decode(logic [7:0] opc);
    case (opc)
      OPC_READ:  return BOP_READ;
      OPC_WRITE: return BOP_WRITE;
      OPC_WRRD:  return BOP_WRRD;
      default:   return BOP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pio_seq_cfg.sv
module pio_seq_cfg #(
  parameter int LEN_W = 7,
  parameter int TGT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctl_i,
  input  logic             wr_cnt_i,
  input  logic             wr_tgt_i,
  input  logic             wr_opc_i,
  input  logic [TGT_W-1:0] wdata_i,
  output logic [LEN_W-1:0] count_o,
  output logic [TGT_W-1:0] target_o,
  output logic [7:0]       opcode_o,
  output logic             irq_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o  <= '0;
      target_o <= '0;
      opcode_o <= '0;
      irq_en_o <= 1'b0;
    end else begin
      if (wr_ctl_i) irq_en_o <= wdata_i[1];
      if (wr_cnt_i) count_o  <= wdata_i[LEN_W-1:0];
      if (wr_tgt_i) target_o <= wdata_i;
      if (wr_opc_i) opcode_o <= wdata_i[7:0];
    end
  end
endmodule

// File: rtl/pio_seq_buf.sv
module pio_seq_buf #(
  parameter int NUM_WORDS = 16,
  localparam int WIDX_W = $clog2(NUM_WORDS),
  localparam int BIDX_W = WIDX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wwe_i,
  input  logic [WIDX_W-1:0] widx_i,
  input  logic [31:0]       wdata_i,
  input  logic [WIDX_W-1:0] ridx_i,
  output logic [31:0]       rword_o,
  input  logic              bwe_i,
  input  logic [BIDX_W-1:0] bwidx_i,
  input  logic [7:0]        bwdata_i,
  input  logic [BIDX_W-1:0] bridx_i,
  output logic [7:0]        brdata_o
);
  logic [31:0] mem_q [NUM_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NUM_WORDS; w++) mem_q[w] <= '0;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (bwe_i && bwidx_i[BIDX_W-1:2] == WIDX_W'(w))
          mem_q[w][8*bwidx_i[1:0] +: 8] <= bwdata_i;
        else if (wwe_i && widx_i == WIDX_W'(w))
          mem_q[w] <= wdata_i;
      end
    end
  end

  // byte lanes of the addressed word, selected for the outbound stream
  logic [31:0] tx_word;
  logic [7:0]  lane [4];
  assign tx_word = mem_q[bridx_i[BIDX_W-1:2]];
  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign lane[l] = tx_word[8*l +: 8];
  end
  assign brdata_o = lane[bridx_i[1:0]];
  assign rword_o  = mem_q[ridx_i];
endmodule

// File: rtl/pio_seq_fsm.sv
module pio_seq_fsm
  import pio_seq_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  localparam int MAX_BYTES = NUM_WORDS * 4,
  localparam int LEN_W  = $clog2(MAX_BYTES + 1),
  localparam int BIDX_W = $clog2(MAX_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [LEN_W-1:0]  count_i,
  input  logic [7:0]        opcode_i,
  input  logic [2:0]        st_clr_i,   // {cfg_err, seq_err, done}
  input  logic              seq_viol_i,
  input  logic              bus_done_i,
  input  logic              tx_ready_i,
  input  logic              rx_valid_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              seq_err_o,
  output logic              cfg_err_o,
  output logic [1:0]        bus_op_o,
  output logic              tx_valid_o,
  output logic [BIDX_W-1:0] tx_idx_o,
  output logic              rx_we_o,
  output logic [BIDX_W-1:0] rx_idx_o
);
  bus_op_e          op;
  logic             has_wr, has_rd, len_ok, launch, finish;
  logic             rx_en, tx_fire;
  logic [LEN_W-1:0] tx_cnt_q, rx_cnt_q;

  assign op      = op_decode(opcode_i);
  assign has_wr  = (op == BOP_WRITE) || (op == BOP_WRRD);
  assign has_rd  = (op == BOP_READ) || (op == BOP_WRRD);
  assign len_ok  = (count_i != '0) && (count_i <= LEN_W'(MAX_BYTES));
  assign launch  = go_i && len_ok && (op != BOP_NONE);
  assign finish  = busy_o && bus_done_i;

  assign tx_valid_o = busy_o && has_wr && (tx_cnt_q < count_i);
  assign tx_fire    = tx_valid_o && tx_ready_i;
  // write-then-read: inbound bytes accepted only after the last outbound byte
  assign rx_en      = busy_o && has_rd && (rx_cnt_q < count_i) &&
                      ((op != BOP_WRRD) || (tx_cnt_q == count_i));
  assign rx_we_o    = rx_en && rx_valid_i;
  assign tx_idx_o   = tx_cnt_q[BIDX_W-1:0];
  assign rx_idx_o   = rx_cnt_q[BIDX_W-1:0];
  assign bus_op_o   = busy_o ? op : BOP_NONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      seq_err_o <= 1'b0;
      cfg_err_o <= 1'b0;
      tx_cnt_q  <= '0;
      rx_cnt_q  <= '0;
    end else begin
      if (launch) begin
        busy_o   <= 1'b1;
        tx_cnt_q <= '0;
        rx_cnt_q <= '0;
      end else begin
        if (finish)  busy_o   <= 1'b0;
        if (tx_fire) tx_cnt_q <= tx_cnt_q + 1'b1;
        if (rx_we_o) rx_cnt_q <= rx_cnt_q + 1'b1;
      end
      done_o    <= finish                 | (done_o    & ~st_clr_i[0]);
      seq_err_o <= seq_viol_i             | (seq_err_o & ~st_clr_i[1]);
      cfg_err_o <= (go_i && !launch)      | (cfg_err_o & ~st_clr_i[2]);
    end
  end
endmodule

// File: rtl/pio_seq.sv
module pio_seq
  import pio_seq_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int TGT_W     = 24,
  localparam int MAX_BYTES = NUM_WORDS * 4,
  localparam int LEN_W  = $clog2(MAX_BYTES + 1),
  localparam int BIDX_W = $clog2(MAX_BYTES),
  localparam int WIDX_W = $clog2(NUM_WORDS),
  localparam int RA_W   = WIDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [RA_W-1:0]  reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             irq_o,
  output logic             bus_req_o,
  output logic [1:0]       bus_op_o,
  output logic [TGT_W-1:0] bus_addr_o,
  output logic [LEN_W-1:0] bus_len_o,
  input  logic             bus_done_i,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  input  logic             tx_ready_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i
);
  logic is_data, hit_ctl, hit_cnt, hit_tgt, hit_opc, hit_sts;
  logic guarded_wr, open_wr, go;
  logic busy, st_done, st_seq, st_cfg, irq_en;
  logic [LEN_W-1:0]  cfg_count;
  logic [TGT_W-1:0]  cfg_target;
  logic [7:0]        cfg_opcode;
  logic [2:0]        st_clr;
  logic [31:0]       rword;
  logic [BIDX_W-1:0] tx_idx, rx_idx;
  logic              rx_we;

  assign is_data = reg_addr_i[RA_W-1];
  assign hit_ctl = reg_addr_i == RA_W'(REG_CTRL);
  assign hit_cnt = reg_addr_i == RA_W'(REG_COUNT);
  assign hit_tgt = reg_addr_i == RA_W'(REG_TARGET);
  assign hit_opc = reg_addr_i == RA_W'(REG_OPCODE);
  assign hit_sts = reg_addr_i == RA_W'(REG_STATUS);

  assign guarded_wr = reg_wr_i && (is_data || hit_ctl || hit_cnt || hit_tgt || hit_opc);
  assign open_wr    = reg_wr_i && !busy;
  assign go         = open_wr && hit_ctl && reg_wdata_i[0];
  assign st_clr     = (reg_wr_i && hit_sts) ? reg_wdata_i[3:1] : 3'b000;

  pio_seq_cfg #(.LEN_W(LEN_W), .TGT_W(TGT_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_ctl_i (open_wr && hit_ctl),
    .wr_cnt_i (open_wr && hit_cnt),
    .wr_tgt_i (open_wr && hit_tgt),
    .wr_opc_i (open_wr && hit_opc),
    .wdata_i  (reg_wdata_i[TGT_W-1:0]),
    .count_o  (cfg_count),
    .target_o (cfg_target),
    .opcode_o (cfg_opcode),
    .irq_en_o (irq_en)
  );

  pio_seq_buf #(.NUM_WORDS(NUM_WORDS)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wwe_i    (open_wr && is_data),
    .widx_i   (reg_addr_i[WIDX_W-1:0]),
    .wdata_i  (reg_wdata_i),
    .ridx_i   (reg_addr_i[WIDX_W-1:0]),
    .rword_o  (rword),
    .bwe_i    (rx_we),
    .bwidx_i  (rx_idx),
    .bwdata_i (rx_data_i),
    .bridx_i  (tx_idx),
    .brdata_o (tx_data_o)
  );

  pio_seq_fsm #(.NUM_WORDS(NUM_WORDS)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go),
    .count_i    (cfg_count),
    .opcode_i   (cfg_opcode),
    .st_clr_i   (st_clr),
    .seq_viol_i (busy && guarded_wr),
    .bus_done_i (bus_done_i),
    .tx_ready_i (tx_ready_i),
    .rx_valid_i (rx_valid_i),
    .busy_o     (busy),
    .done_o     (st_done),
    .seq_err_o  (st_seq),
    .cfg_err_o  (st_cfg),
    .bus_op_o   (bus_op_o),
    .tx_valid_o (tx_valid_o),
    .tx_idx_o   (tx_idx),
    .rx_we_o    (rx_we),
    .rx_idx_o   (rx_idx)
  );

  assign bus_req_o  = busy;
  assign bus_addr_o = cfg_target;
  assign bus_len_o  = cfg_count;
  assign irq_o      = st_done && irq_en;

  always_comb begin
    reg_rdata_o = '0;
    if (is_data)      reg_rdata_o = rword;
    else if (hit_ctl) reg_rdata_o = {30'd0, irq_en, busy};
    else if (hit_cnt) reg_rdata_o = 32'(cfg_count);
    else if (hit_tgt) reg_rdata_o = 32'(cfg_target);
    else if (hit_opc) reg_rdata_o = 32'(cfg_opcode);
    else if (hit_sts) reg_rdata_o = {28'd0, st_cfg, st_seq, st_done, busy};
  end
endmodule

// File: rtl/pio_seq_chk.sv
module pio_seq_chk
  import pio_seq_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  localparam int MAX_BYTES = NUM_WORDS * 4,
  localparam int LEN_W = $clog2(MAX_BYTES + 1),
  localparam int RA_W  = $clog2(NUM_WORDS) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic [RA_W-1:0]  reg_addr_i,
  input logic             wdata0_i,
  input logic             bus_done_i,
  input logic             irq_o,
  input logic             tx_valid_o,
  input logic             busy,
  input logic             done,
  input logic             seq_err,
  input logic             cfg_err,
  input logic [LEN_W-1:0] count_q
);
  assert_refuse_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && reg_wr_i && reg_addr_i != RA_W'(REG_STATUS) |=> seq_err);

  assert_count_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && reg_wr_i && reg_addr_i == RA_W'(REG_COUNT) |=> count_q == $past(count_q));

  assert_finish_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && bus_done_i |=> !busy && done);

  assert_bad_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && reg_wr_i && reg_addr_i == RA_W'(REG_CTRL) && wdata0_i &&
    (count_q == '0 || count_q > LEN_W'(MAX_BYTES)) |=> !busy && cfg_err);

  assert_irq_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done);

  assert_tx_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> busy);
endmodule

bind pio_seq pio_seq_chk #(.NUM_WORDS(NUM_WORDS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .wdata0_i   (reg_wdata_i[0]),
  .bus_done_i (bus_done_i),
  .irq_o      (irq_o),
  .tx_valid_o (tx_valid_o),
  .busy       (busy),
  .done       (st_done),
  .seq_err    (st_seq),
  .cfg_err    (st_cfg),
  .count_q    (cfg_count)
);

// File: tb/pio_seq_tb.sv
`timescale 1ns/1ps
module pio_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, bus_req_o, tx_valid_o;
  logic [1:0]  bus_op_o;
  logic [23:0] bus_addr_o;
  logic [6:0]  bus_len_o;
  logic [7:0]  tx_data_o;
  logic        bus_done_i = 1'b0;
  logic        tx_ready_i = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;

  int checks = 0;
  int errors = 0;
  int tx_seen = 0;
  logic [7:0] exp_q[$];
  logic [31:0] rd;

  always #2 clk_i = ~clk_i;

  pio_seq u_dut (.*);

  function automatic logic [7:0] pat(int k);
    return 8'((k * 37 + 5) & 255);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: outbound bytes against the queue the driver filled
  always @(negedge clk_i) begin
    if (rst_ni && tx_valid_o && tx_ready_i) begin
      tx_seen++;
      if (exp_q.size() == 0) check("R3 unexpected tx byte", {24'd0, tx_data_o}, 32'hFFFF_FFFF);
      else check("R3 tx byte", {24'd0, tx_data_o}, {24'd0, exp_q.pop_front()});
    end
  end

  task automatic reg_write(logic [4:0] a, logic [31:0] d);
    @(posedge clk_i); #1;
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_wr_i = 1'b0;
  endtask

  task automatic reg_read(logic [4:0] a, output logic [31:0] d);
    @(posedge clk_i); #1;
    reg_addr_i = a;
    @(negedge clk_i);
    d = reg_rdata_o;
  endtask

  // register write landing in the same cycle as the engine's done
  task automatic write_with_done(logic [4:0] a, logic [31:0] d);
    @(posedge clk_i); #1;
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; bus_done_i = 1'b1;
    @(posedge clk_i); #1;
    reg_wr_i = 1'b0; bus_done_i = 1'b0;
  endtask

  task automatic send_rx(logic [7:0] b);
    @(posedge clk_i); #1;
    rx_valid_i = 1'b1; rx_data_i = b;
    @(posedge clk_i); #1;
    rx_valid_i = 1'b0;
  endtask

  task automatic load_pattern(int nbytes);
    for (int w = 0; w < (nbytes + 3) / 4; w++)
      reg_write(5'(16 + w), {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});
    for (int k = 0; k < nbytes; k++) exp_q.push_back(pat(k));
  endtask

  task automatic wait_tx(int n);
    while (tx_seen < n) @(negedge clk_i);
    @(posedge clk_i); #1;
    tx_ready_i = 1'b0;
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    reg_read(5'd4, rd);  check("R1 status", rd, 0);
    reg_read(5'd1, rd);  check("R1 count", rd, 0);
    reg_read(5'd16, rd); check("R1 data0", rd, 0);
    check("R1 outputs", {29'd0, bus_req_o, tx_valid_o, irq_o}, 0);

    // R2/R3 write transfer of 7 bytes, R6 refused writes while busy
    load_pattern(7);
    reg_write(5'd1, 7);
    reg_write(5'd2, 24'h00ABCD);
    reg_write(5'd3, 8'hA2);
    tx_seen = 0;
    reg_write(5'd0, 32'h3);
    @(negedge clk_i);
    check("R2 bus req", {31'd0, bus_req_o}, 1);
    check("R2 bus op", {30'd0, bus_op_o}, 2);
    check("R2 bus len", {25'd0, bus_len_o}, 7);
    check("R2 bus addr", {8'd0, bus_addr_o}, 32'h00ABCD);
    tx_ready_i = 1'b1;
    reg_write(5'd1, 3);
    reg_read(5'd1, rd);  check("R6 count kept", rd, 7);
    reg_read(5'd0, rd);  check("R2 go reads busy", rd, 32'h3);
    reg_read(5'd4, rd);  check("R6 seq err while busy", rd, 32'h5);
    wait_tx(7);
    @(negedge clk_i);
    check("R10 tx idle after count", {31'd0, tx_valid_o}, 0);
    // collision: refused data write together with done
    write_with_done(5'd16, 32'hDEAD_BEEF);
    reg_read(5'd4, rd);  check("R2 R6 status after collision", rd, 32'h6);
    reg_read(5'd16, rd); check("R6 data kept", rd, {pat(3), pat(2), pat(1), pat(0)});
    reg_read(5'd0, rd);  check("R2 go self-cleared", rd, 32'h2);
    check("R9 irq with enable", {31'd0, irq_o}, 1);
    check("R3 queue drained", exp_q.size(), 0);

    // R8 clear seq err only; done stays
    reg_write(5'd4, 32'h4);
    reg_read(5'd4, rd);  check("R8 partial clear", rd, 32'h2);

    // R4 read of 5 bytes, R8 clear colliding with new done, R9 irq disabled
    reg_write(5'd16, 32'hFFFF_FFFF);
    reg_write(5'd17, 32'hFFFF_FFFF);
    reg_write(5'd1, 5);
    reg_write(5'd3, 8'hA1);
    reg_write(5'd0, 32'h1);
    for (int k = 0; k < 6; k++) send_rx(8'(8'h51 + k));
    write_with_done(5'd4, 32'h2);
    reg_read(5'd4, rd);  check("R8 set beats clear", rd, 32'h2);
    check("R9 irq disabled", {31'd0, irq_o}, 0);
    reg_read(5'd16, rd); check("R4 word0", rd, 32'h5453_5251);
    reg_read(5'd17, rd); check("R4 R10 word1", rd, 32'hFFFF_FF55);
    reg_write(5'd4, 32'h2);
    reg_read(5'd4, rd);  check("R8 done cleared", rd, 0);

    // R5 write-then-read of 4 bytes, early rx ignored
    reg_write(5'd16, 32'h4433_2211);
    exp_q.push_back(8'h11); exp_q.push_back(8'h22);
    exp_q.push_back(8'h33); exp_q.push_back(8'h44);
    reg_write(5'd1, 4);
    reg_write(5'd3, 8'hA3);
    tx_seen = 0;
    reg_write(5'd0, 32'h1);
    send_rx(8'hEE);
    tx_ready_i = 1'b1;
    wait_tx(4);
    for (int k = 0; k < 4; k++) send_rx(8'(8'hA1 + k));
    write_with_done(5'd4, 32'h0);
    reg_read(5'd16, rd); check("R5 readback", rd, 32'hA4A3_A2A1);
    check("R5 queue drained", exp_q.size(), 0);
    reg_write(5'd4, 32'h2);

    // R7 rejected configurations
    reg_write(5'd3, 8'hA2);
    reg_write(5'd1, 0);
    reg_write(5'd0, 32'h1);
    check("R7 no req count 0", {31'd0, bus_req_o}, 0);
    reg_read(5'd4, rd);  check("R7 count 0", rd, 32'h8);
    reg_write(5'd4, 32'h8);
    reg_write(5'd1, 65);
    reg_write(5'd0, 32'h1);
    reg_read(5'd4, rd);  check("R7 count 65", rd, 32'h8);
    reg_write(5'd4, 32'h8);
    reg_write(5'd1, 4);
    reg_write(5'd3, 8'h55);
    reg_write(5'd0, 32'h1);
    @(negedge clk_i);
    check("R7 no req bad opcode", {31'd0, bus_req_o}, 0);
    reg_read(5'd4, rd);  check("R7 bad opcode", rd, 32'h8);
    reg_write(5'd4, 32'h8);

    // R3 full 64-byte write with stalling engine
    load_pattern(64);
    reg_write(5'd1, 64);
    reg_write(5'd3, 8'hA2);
    tx_seen = 0;
    reg_write(5'd0, 32'h1);
    while (tx_seen < 64) begin
      @(posedge clk_i); #1;
      tx_ready_i = ~tx_ready_i;
    end
    tx_ready_i = 1'b0;
    @(negedge clk_i);
    check("R10 tx idle after 64", {31'd0, tx_valid_o}, 0);
    write_with_done(5'd4, 32'h0);
    reg_read(5'd4, rd);  check("R2 done after 64", rd, 32'h2);
    check("R3 queue drained 64", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule